// File: doc/BRIEF.md
# Doorbell Interrupt Status Controller

This block sits behind a request decoder and turns doorbell requests into interrupt status. Each doorbell carries a 16-bit info field that names exactly one of 64 status bits, arranged as four 16-bit status registers. The block answers every doorbell on a valid/ready response port. The answer is done if the bit was free and is now set. It is retry if the bit is still set from an earlier doorbell, since no bit queues more than one event. It is error if the field has any bit outside the decoded range. A retry changes nothing, and an error changes nothing.

Doorbells share the request input with data write and read requests, and are taken in arrival order. A counter tracks data writes that have been issued but have not yet completed. While that counter is non-zero, a doorbell is held at the input with ready low, so the interrupt can never be seen before the data it announces has landed. Software releases a status bit by writing a one to the matching position of a clear strobe. A routing table gives each status bit a core index. Each core's interrupt line is the OR of all set status bits routed to it.

Top module: `dbell_irq_ctrl`

## Requirements
- R1: A doorbell with info bits [15:6] all zero addresses status bit index info[5:0], which is register info[5:4], bit info[3:0]. If that bit is 0, the bit becomes 1 after the accepting edge and the response code is 2'b00 (done).
- R2: A doorbell with any of info bits [15:6] set gets response code 2'b10 (error) and changes no status bit.
- R3: A doorbell that addresses a status bit that is already 1 gets response code 2'b01 (retry) and leaves that bit at 1.
- R4: A cycle with clr_valid high clears every status bit at index clr_sel*16+k whose clr_mask[k] is 1. If the same edge also sets that bit from a doorbell, the bit ends at 1.
- R5: After all status bits are cleared, 64 doorbells with distinct info values 0..63 all get done responses, and all 64 status bits end at 1.
- R6: A request with req_is_wr high and req_is_db low increments the outstanding-write count when accepted, and each wr_done pulse decrements it. While that count is non-zero, req_ready is low for a request with req_is_db high. A request with req_is_db low is always ready.
- R7: The response appears in the cycle after the doorbell is accepted and carries the request's req_id. It is held unchanged until rsp_ready is high. While an unaccepted response is held, req_ready is low for doorbells.
- R8: rt_wr_en writes core index rt_core into the routing entry of status bit rt_idx. irq[c] is the OR of all status bits whose entry equals c.
- R9: After reset, all status bits are 0, every routing entry is core 0, irq is 0, rsp_valid is 0, and the write count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_is_db | input | 1 | Request is a doorbell (takes precedence over req_is_wr) |
| req_is_wr | input | 1 | Request is a posted data write |
| req_info | input | 16 | Doorbell info field |
| req_id | input | ID_W | Transaction identifier |
| wr_done | input | 1 | One issued data write has completed to memory |
| rsp_valid | output | 1 | Doorbell response present |
| rsp_ready | input | 1 | Response taken at this edge when valid |
| rsp_code | output | 2 | 00 done, 01 retry, 10 error |
| rsp_id | output | ID_W | Identifier of the answered doorbell |
| clr_valid | input | 1 | Software clear strobe |
| clr_sel | input | 2 | Status register to clear |
| clr_mask | input | 16 | Bits to clear in that register |
| rt_wr_en | input | 1 | Routing entry write strobe |
| rt_idx | input | 6 | Status bit whose routing entry is written |
| rt_core | input | CORE_W | Core index to store |
| status | output | 64 | Status bits, index = register*16 + bit |
| irq | output | NUM_CORES | Per-core interrupt lines |

## Verification
Two events can fall in the same cycle. The first is a software clear and a doorbell set on the same status bit. The second is a write completion and a doorbell waiting behind the write fence. The bench provokes the first directly: it drives a doorbell and a clear of the same free bit on one edge, and requires the bit to end set. The random phase also produces the case where the clear meets a doorbell that sees the bit still set, which must return retry while the bit drops. For the second case, the bench releases pending writes one wr_done at a time under a held doorbell. A behavioural model then judges req_ready on every cycle, so acceptance must come exactly in the cycle after the count reaches zero, and not earlier.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int INFO_W = 16;
  localparam int SEL_W  = 2;
  localparam int BIT_W  = 4;
  localparam int NREG   = 1 << SEL_W;
  localparam int REG_W  = 1 << BIT_W;
  localparam int NSRC   = NREG * REG_W;
  localparam int IDX_W  = SEL_W + BIT_W;

  typedef enum logic [1:0] {
    RSP_DONE  = 2'b00,
    RSP_RETRY = 2'b01,
    RSP_ERROR = 2'b10
  } rsp_code_e;

  // True when any non-decoded info bit is set
  function automatic logic info_has_reserved(input logic [INFO_W-1:0] info);
    return |info[INFO_W-1:IDX_W];
  endfunction

  // Flat status index: register select above bit select
  function automatic logic [IDX_W-1:0] info_to_index(input logic [INFO_W-1:0] info);
    return {info[BIT_W +: SEL_W], info[0 +: BIT_W]};
  endfunction
endpackage

// File: rtl/dbell_fence.sv
module dbell_fence #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_issue,
  input  logic             wr_done,
  output logic             drained,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (wr_issue && !wr_done) count <= count + 1'b1;
    else if (!wr_issue && wr_done) count <= count - 1'b1;
  end

  assign drained = (count == '0);

  // R6: a completion never arrives with nothing outstanding
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !wr_issue) |-> !drained);
endmodule

// File: rtl/dbell_status.sv
module dbell_status
  import dbell_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 clr_valid,
  input  logic [SEL_W-1:0]     clr_sel,
  input  logic [REG_W-1:0]     clr_mask,
  output logic [NSRC-1:0]      status
);
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] set_vec;

  for (genvar r = 0; r < NREG; r++) begin : g_clr
    assign clr_vec[r*REG_W +: REG_W] =
      (clr_valid && clr_sel == SEL_W'(r)) ? clr_mask : '0;
  end

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  // R4: a set on the same edge as a clear of that bit leaves it high
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_vec[set_idx]) |=> status[$past(set_idx)]);
endmodule

// File: rtl/dbell_route.sv
module dbell_route
  import dbell_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rt_wr_en,
  input  logic [IDX_W-1:0]     rt_idx,
  input  logic [CORE_W-1:0]    rt_core,
  input  logic [NSRC-1:0]      status,
  output logic [NUM_CORES-1:0] irq
);
  logic [CORE_W-1:0] tbl [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) tbl[s] <= '0;
    end else if (rt_wr_en) begin
      tbl[rt_idx] <= rt_core;
    end
  end

  always_comb begin
    irq = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (tbl[s] == CORE_W'(c)) irq[c] = irq[c] | status[s];
      end
    end
  end

  // R8: no interrupt without some status bit set
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (irq == '0));
endmodule

// File: rtl/dbell_irq_ctrl.sv
module dbell_irq_ctrl
  import dbell_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_is_db,
  input  logic                 req_is_wr,
  input  logic [15:0]          req_info,
  input  logic [ID_W-1:0]      req_id,
  input  logic                 wr_done,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_code,
  output logic [ID_W-1:0]      rsp_id,
  input  logic                 clr_valid,
  input  logic [1:0]           clr_sel,
  input  logic [15:0]          clr_mask,
  input  logic                 rt_wr_en,
  input  logic [5:0]           rt_idx,
  input  logic [((NUM_CORES > 1) ? $clog2(NUM_CORES) : 1)-1:0] rt_core,
  output logic [63:0]          status,
  output logic [NUM_CORES-1:0] irq
);
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  // Named internal events
  logic             fence_drained;
  logic [CNT_W-1:0] wr_count;
  logic             rsp_stuck;
  logic             accept;
  logic             db_accept;
  logic             wr_issue;
  logic             info_bad;
  logic [IDX_W-1:0] db_idx;
  logic             bit_busy;
  logic             db_set;
  rsp_code_e        db_code;

  assign rsp_stuck = rsp_valid && !rsp_ready;
  assign req_ready = !req_is_db || (fence_drained && !rsp_stuck);
  assign accept    = req_valid && req_ready;
  assign db_accept = accept && req_is_db;
  assign wr_issue  = accept && !req_is_db && req_is_wr;

  assign info_bad = info_has_reserved(req_info);
  assign db_idx   = info_to_index(req_info);
  assign bit_busy = status[db_idx];
  assign db_set   = db_accept && !info_bad && !bit_busy;

  always_comb begin
    if (info_bad)      db_code = RSP_ERROR;
    else if (bit_busy) db_code = RSP_RETRY;
    else               db_code = RSP_DONE;
  end

  dbell_fence #(.CNT_W(CNT_W)) u_fence (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_issue (wr_issue),
    .wr_done  (wr_done),
    .drained  (fence_drained),
    .count    (wr_count)
  );

  dbell_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (db_set),
    .set_idx   (db_idx),
    .clr_valid (clr_valid),
    .clr_sel   (clr_sel),
    .clr_mask  (clr_mask),
    .status    (status)
  );

  dbell_route #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .rt_wr_en (rt_wr_en),
    .rt_idx   (rt_idx),
    .rt_core  (rt_core),
    .status   (status),
    .irq      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 2'b00;
      rsp_id    <= '0;
    end else if (db_accept) begin
      rsp_valid <= 1'b1;
      rsp_code  <= db_code;
      rsp_id    <= req_id;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R6: doorbells wait behind outstanding writes
  a_r6_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_db && wr_count != '0) |-> !req_ready);

  // R7: an unaccepted response holds still
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_id)));

  // R1: a free, well-formed target bit is set and answered done
  a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
    (db_accept && !info_bad && !bit_busy) |=> (status[$past(db_idx)] && rsp_code == 2'b00));

  // R2: a malformed field changes no status bit
  a_r2_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (db_accept && info_bad && !clr_valid) |=> ($stable(status) && rsp_code == 2'b10));

  // R3: a busy target gets retry and stays set
  a_r3_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (db_accept && !info_bad && bit_busy && !clr_valid) |=> (rsp_code == 2'b01 && status[$past(db_idx)]));
endmodule

// File: tb/dbell_irq_ctrl_test.sv
module dbell_irq_ctrl_test;
  localparam int NC = 4;
  localparam int IDW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_is_db = 0, req_is_wr = 0;
  logic [15:0] req_info = '0;
  logic [IDW-1:0] req_id = '0;
  logic wr_done = 0, rsp_ready = 1;
  logic clr_valid = 0;
  logic [1:0] clr_sel = '0;
  logic [15:0] clr_mask = '0;
  logic rt_wr_en = 0;
  logic [5:0] rt_idx = '0;
  logic [1:0] rt_core = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_code;
  logic [IDW-1:0] rsp_id;
  logic [63:0] status;
  logic [NC-1:0] irq;

  dbell_irq_ctrl #(.NUM_CORES(NC), .ID_W(IDW), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_db(req_is_db), .req_is_wr(req_is_wr), .req_info(req_info),
    .req_id(req_id), .wr_done(wr_done), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_id(rsp_id),
    .clr_valid(clr_valid), .clr_sel(clr_sel), .clr_mask(clr_mask),
    .rt_wr_en(rt_wr_en), .rt_idx(rt_idx), .rt_core(rt_core),
    .status(status), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, done_seen = 0;
  bit finished = 0;

  // Behavioural reference state
  bit [63:0] m_stat = '0;
  int m_route[64];
  int m_cnt = 0;
  bit m_rv = 0;
  int m_code = 0;
  int m_id = 0;

  initial for (int s = 0; s < 64; s++) m_route[s] = 0;

  function automatic bit exp_ready();
    if (!req_is_db) return 1'b1;
    return (m_cnt == 0) && !(m_rv && !rsp_ready);
  endfunction

  function automatic bit [NC-1:0] exp_irq();
    bit [NC-1:0] v = '0;
    for (int s = 0; s < 64; s++) if (m_stat[s]) v[m_route[s]] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model advance at each edge from the inputs and the old model state
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_cnt = 0; m_rv = 0; m_code = 0; m_id = 0;
      for (int s = 0; s < 64; s++) m_route[s] = 0;
    end else begin
      bit acc;
      bit [63:0] setv, clrv;
      acc = req_valid && exp_ready();
      setv = '0; clrv = '0;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc && req_is_db) begin
        m_rv = 1; m_id = req_id;
        if (req_info[15:6] != 0) m_code = 2;
        else if (m_stat[req_info[5:0]]) m_code = 1;
        else begin m_code = 0; setv[req_info[5:0]] = 1'b1; end
      end
      if (clr_valid) for (int k = 0; k < 16; k++) if (clr_mask[k]) clrv[clr_sel*16+k] = 1'b1;
      m_stat = (m_stat & ~clrv) | setv;
      if (acc && !req_is_db && req_is_wr) m_cnt++;
      if (wr_done) m_cnt--;
      if (rt_wr_en) m_route[rt_idx] = rt_core;
    end
  end

  // Compare away from the edge on every cycle
  always @(negedge clk) begin
    #5;
    if (!finished) begin
      chk(req_ready == exp_ready(), "R6 req_ready", req_ready, exp_ready());
      chk(rsp_valid == m_rv, "R7 rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        chk(rsp_id == IDW'(m_id), "R7 rsp_id", rsp_id, m_id);
        chk(rsp_code == 2'(m_code),
            m_code == 0 ? "R1 done code" : (m_code == 1 ? "R3 retry code" : "R2 error code"),
            rsp_code, m_code);
      end
      chk(status == m_stat, "R1 R2 R3 R4 status", status, m_stat);
      chk(irq == exp_irq(), "R8 irq", irq, exp_irq());
      if (rsp_valid && rsp_ready && rsp_code == 2'b00) done_seen++;
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_is_db = 0; req_is_wr = 0; wr_done = 0;
    clr_valid = 0; rt_wr_en = 0;
  endtask

  task automatic send(input bit db, input bit wr, input logic [15:0] info, input int id);
    bit r;
    @(negedge clk);
    req_valid = 1; req_is_db = db; req_is_wr = wr; req_info = info; req_id = IDW'(id);
    clr_valid = 0; rt_wr_en = 0;
    do begin
      #5; r = req_ready;
      @(posedge clk);
    end while (!r);
  endtask

  task automatic clear(input int sel, input logic [15:0] mask);
    @(negedge clk);
    req_valid = 0; clr_valid = 1; clr_sel = 2'(sel); clr_mask = mask;
  endtask

  task automatic route(input int idx, input int core);
    @(negedge clk);
    req_valid = 0; clr_valid = 0; rt_wr_en = 1; rt_idx = 6'(idx); rt_core = 2'(core);
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog expired");
    errors++;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk(status == 0 && irq == 0 && !rsp_valid, "R9 reset state", status, 0);
    rst_n = 1;
    idle();
    #5;
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

    // Routing: spread some bits over cores
    route(19, 2); route(5, 1); route(63, 3); route(40, 1);
    idle();

    // R1: register 1, bit 3
    send(1, 0, 16'h0013, 1); idle(); idle();
    #5; chk(status[19] == 1'b1, "R1 bit 19 set", status[19], 1);
    chk(irq[2] == 1'b1, "R8 irq core 2", irq, 4);
    // R3: repeat gets retry
    send(1, 0, 16'h0013, 2); idle();
    #5; chk(rsp_code == 2'b01, "R3 repeat retry", rsp_code, 1);
    // R2: reserved bit set
    send(1, 0, 16'h0040, 3); idle();
    #5; chk(rsp_code == 2'b10, "R2 reserved error", rsp_code, 2);
    send(1, 0, 16'h8005, 4); idle();
    #5; chk(status[5] == 1'b0, "R2 no set on error", status[5], 0);
    // R4: clear then re-ring
    clear(1, 16'h0008); idle();
    #5; chk(status[19] == 1'b0, "R4 cleared", status[19], 0);
    send(1, 0, 16'h0013, 5); idle();
    #5; chk(rsp_code == 2'b00, "R4 done after clear", rsp_code, 0);

    // R6: fence behind three writes
    send(0, 1, 16'h0, 6); send(0, 1, 16'h0, 7); send(0, 1, 16'h0, 8);
    send(0, 0, 16'h0, 9);
    fork
      send(1, 0, 16'h0025, 10);
      begin
        for (int w = 0; w < 3; w++) begin
          @(negedge clk); #1; wr_done = 1;
          @(negedge clk); #1; wr_done = 0;
        end
      end
    join
    idle(); idle();
    #5; chk(status[37] == 1'b1, "R6 doorbell after writes", status[37], 1);

    // R4: clear and set of the same free bit on one edge
    @(negedge clk);
    req_valid = 1; req_is_db = 1; req_is_wr = 0; req_info = 16'h0005; req_id = 8'd11;
    clr_valid = 1; clr_sel = 0; clr_mask = 16'h0020;
    idle();
    #5; chk(status[5] == 1'b1, "R4 set wins", status[5], 1);
    chk(irq[1] == 1'b1, "R8 irq core 1", irq, 2);

    // R7: response held while rsp_ready low
    @(negedge clk); rsp_ready = 0;
    send(1, 0, 16'h0030, 12); idle();
    repeat (3) idle();
    #5; chk(rsp_valid && rsp_id == 8'd12, "R7 held response", rsp_id, 12);
    rsp_ready = 1; idle();

    // R5: 64 distinct doorbells after a full clear
    for (int r = 0; r < 4; r++) clear(r, 16'hFFFF);
    idle(); idle();
    done_seen = 0;
    for (int i = 0; i < 64; i++) send(1, 0, 16'(i), i);
    idle(); idle(); idle();
    #5;
    chk(done_seen == 64, "R5 distinct all done", done_seen, 64);
    chk(status == 64'hFFFF_FFFF_FFFF_FFFF, "R5 all bits set", status, 64'hFFFF_FFFF_FFFF_FFFF);

    // Random mix, model compared every cycle
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      req_valid = ($urandom % 3) != 0;
      req_is_db = ($urandom % 2) == 0;
      req_is_wr = ($urandom % 2) == 0;
      req_info  = (($urandom % 8) == 0) ? 16'(1 << (6 + $urandom % 10)) : 16'($urandom % 64);
      req_id    = IDW'($urandom);
      wr_done   = (m_cnt > 0) && (($urandom % 3) == 0);
      rsp_ready = ($urandom % 4) != 0;
      clr_valid = ($urandom % 3) == 0;
      clr_sel   = 2'($urandom);
      clr_mask  = 16'($urandom);
      rt_wr_en  = ($urandom % 5) == 0;
      rt_idx    = 6'($urandom);
      rt_core   = 2'($urandom);
    end
    idle(); rsp_ready = 1;
    repeat (3) idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule